// File: doc/BRIEF.md
# Multi-Channel Receive Copy Scheduler

This block lets several virtual receive channels share one packet buffer and one DMA write engine. Software posts a copy descriptor on a channel: a target address, a requested byte count and a flag that marks the address as virtual. The scheduler puts the channel into one of two index queues. A channel that already holds a partly copied packet goes into the continuation queue. A channel that holds no packet goes into the new-packet queue. A central state machine then serves the channels one at a time. For each one it claims a packet from the buffer if the channel needs one, issues one DMA chunk and writes that channel's status word.

A channel can keep its packet across several partial copies. The block tracks the offset and the bytes left, and reports the bytes still to come in the status word. The address value 1 is a sentinel: a copy to it moves the bookkeeping on without starting any DMA. Each finished copy raises a completion pulse. When the copy releases the last packet held in the buffer, the block also raises a buffer-drained pulse.

The states are:
- Idle.
- Fifo-block, where the machine picks the next channel or waits for a packet.
- Begin-copy, where the chunk size is fixed.
- Copy, where the DMA runs.
- Copy-done, where the status word is written.

The transitions are:
- Idle goes to fifo-block when a request is accepted.
- Fifo-block goes to begin-copy when it pops a queue.
- Begin-copy goes to copy, or straight to copy-done if the target address is the sentinel.
- Copy goes to copy-done when the DMA engine signals done.
- Copy-done goes to idle when both queues are empty and no request arrives that cycle. Otherwise it goes to fifo-block.

Top module: `rcs_sched`

## Requirements
- R1: After reset every channel's status word reads 0 and none of dma_req, intr_dma or intr_empty is asserted.
- R2: An accepted request sets bit 31 (busy) of that channel's status word, visible from the cycle after acceptance. The DMA transfer for it carries descriptor bits 39:0 on dma_addr and descriptor bit 60 on dma_virt. Descriptor bits 59:40 give the requested byte count.
- R3: A request on a channel whose busy bit is set raises req_err in the same cycle and is otherwise ignored: no extra copy and no extra completion for that channel.
- R4: In fifo-block a channel waiting in the continuation queue is always served before any channel in the new-packet queue.
- R5: A request from a channel with no packet waits while the buffer holds no unclaimed packet. Once one is present, the channel claims the oldest unclaimed packet and starts at offset 0.
- R6: The chunk length is the smaller of the requested count and the packet's remaining bytes. dma_off gives the current offset within the packet.
- R7: When the target address equals 1, no DMA request is issued and the copy still completes.
- R8: A copy that finishes the packet writes a status word with bit 30 (complete) set, bits 31 and 29 clear, and the chunk length in bits 19:0. It also pulses rel_valid with the packet id.
- R9: A copy that leaves bytes behind writes a status word with bits 30 and 29 (more) set and the remaining byte count in bits 19:0. The next copy on that channel starts at the advanced offset.
- R10: Each completion pulses intr_dma for one cycle with cpl_chan naming the channel. intr_empty pulses with it when that copy released a packet while the buffer held exactly one packet.
- R11: Channels in the new-packet queue are served in the order their requests were accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Copy request strobe |
| req_chan | input | CH_W | Requesting channel |
| req_desc | input | 61 | Descriptor: 60 virtual flag, 59:40 count, 39:0 address |
| req_err | output | 1 | Request hit a busy channel and was dropped |
| unclaimed_valid | input | 1 | Buffer holds a packet not yet owned by a channel |
| unclaimed_id | input | PID_W | Id of the oldest unclaimed packet |
| unclaimed_len | input | 20 | Byte length of that packet |
| resident_cnt | input | CNT_W | Packets currently held in the buffer |
| claim | output | 1 | Takes the oldest unclaimed packet this cycle |
| rel_valid | output | 1 | Frees a fully copied packet |
| rel_id | output | PID_W | Id of the freed packet |
| dma_req | output | 1 | DMA transfer requested, held until dma_done |
| dma_addr | output | 40 | Target address |
| dma_len | output | 20 | Chunk length |
| dma_off | output | 20 | Offset within the packet |
| dma_pid | output | PID_W | Source packet id |
| dma_virt | output | 1 | Address is virtual |
| dma_done | input | 1 | DMA engine finished the transfer |
| rd_chan | input | CH_W | Channel whose status word is read |
| rd_done | output | 32 | Status word of rd_chan |
| intr_dma | output | 1 | Copy completion pulse |
| intr_empty | output | 1 | Buffer drained pulse |
| cpl_chan | output | CH_W | Channel of the completion |

## Verification
The busy bit follows one register stage after the request edge, so the bench reads it at the next falling edge. The status word, the completion pulse and the drained pulse are all written on the edge that leaves copy-done. A request to a non-sentinel address takes at least four edges to get there plus the DMA latency; a sentinel request takes exactly four. The bench therefore does not count a fixed cycle number. It waits on the logged completion and only then compares the status word, the channel, the packet release and the recorded DMA fields. Queue ordering is checked from the sequence of completions, with the DMA response held back so that every queue fills before any entry is served.

// File: rtl/rcs_pkg.sv
package rcs_pkg;
    localparam int ADDR_W    = 40;
    localparam int LEN_W     = 20;
    localparam int LEN_LSB   = 40;
    localparam int VIRT_BIT  = 60;
    localparam int DESC_W    = 61;
    localparam int DONE_W    = 32;
    localparam int BIT_BUSY  = 31;
    localparam int BIT_CPL   = 30;
    localparam int BIT_MORE  = 29;
    localparam logic [ADDR_W-1:0] NO_DMA_ADDR = ADDR_W'(1);

    typedef enum logic [2:0] {
        S_IDLE,
        S_FIFO_BLK,
        S_BEGIN,
        S_COPY,
        S_DONE
    } rcs_state_t;

    function automatic logic [DONE_W-1:0] mk_done(input logic busy, input logic cpl,
                                                 input logic more, input logic [LEN_W-1:0] len);
        logic [DONE_W-1:0] w;
        w = '0;
        w[BIT_BUSY] = busy;
        w[BIT_CPL]  = cpl;
        w[BIT_MORE] = more;
        w[LEN_W-1:0] = len;
        return w;
    endfunction
endpackage

// File: rtl/rcs_idx_queue.sv
module rcs_idx_queue #(
    parameter int DEPTH = 4,
    parameter int W     = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_idx,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         empty
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  slots [DEPTH];
    logic [PW-1:0] rd_q, wr_q;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (push) slots[wr_q] <= push_idx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q  <= '0;
            wr_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (push) wr_q <= (wr_q == PW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
            if (pop)  rd_q <= (rd_q == PW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
            case ({push, pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    assign head  = slots[rd_q];
    assign empty = (cnt_q == '0);
endmodule

// File: rtl/rcs_chunk_calc.sv
module rcs_chunk_calc #(
    parameter int W = 20
) (
    input  logic [W-1:0] want,
    input  logic [W-1:0] left,
    output logic [W-1:0] chunk,
    output logic         whole
);
    assign whole = (want >= left);
    assign chunk = whole ? left : want;
endmodule

// File: rtl/rcs_sched.sv
module rcs_sched
    import rcs_pkg::*;
#(
    parameter int NCH   = 4,
    parameter int PID_W = 3,
    parameter int CNT_W = 4,
    localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [CH_W-1:0]   req_chan,
    input  logic [DESC_W-1:0] req_desc,
    output logic              req_err,
    input  logic              unclaimed_valid,
    input  logic [PID_W-1:0]  unclaimed_id,
    input  logic [LEN_W-1:0]  unclaimed_len,
    input  logic [CNT_W-1:0]  resident_cnt,
    output logic              claim,
    output logic              rel_valid,
    output logic [PID_W-1:0]  rel_id,
    output logic              dma_req,
    output logic [ADDR_W-1:0] dma_addr,
    output logic [LEN_W-1:0]  dma_len,
    output logic [LEN_W-1:0]  dma_off,
    output logic [PID_W-1:0]  dma_pid,
    output logic              dma_virt,
    input  logic              dma_done,
    input  logic [CH_W-1:0]   rd_chan,
    output logic [DONE_W-1:0] rd_done,
    output logic              intr_dma,
    output logic              intr_empty,
    output logic [CH_W-1:0]   cpl_chan
);
    rcs_state_t state_q, state_d;

    logic [ADDR_W-1:0] ch_addr [NCH];
    logic [LEN_W-1:0]  ch_want [NCH];
    logic [LEN_W-1:0]  ch_off  [NCH];
    logic [LEN_W-1:0]  ch_left [NCH];
    logic [PID_W-1:0]  ch_pid  [NCH];
    logic              ch_virt [NCH];
    logic              ch_has  [NCH];
    logic [DONE_W-1:0] done_q  [NCH];

    logic [CH_W-1:0]  act_ch, sel_ch;
    logic [LEN_W-1:0] act_len, chunk;
    logic             act_full, whole;

    logic req_acc, push_cont, push_new, pop_cont, pop_new;
    logic cont_empty, new_empty;
    logic [CH_W-1:0] cont_head, new_head;

    assign req_err   = req_valid &&  done_q[req_chan][BIT_BUSY];
    assign req_acc   = req_valid && !done_q[req_chan][BIT_BUSY];
    assign push_cont = req_acc &&  ch_has[req_chan];
    assign push_new  = req_acc && !ch_has[req_chan];

    rcs_idx_queue #(.DEPTH(NCH), .W(CH_W)) u_cont_q (
        .clk(clk), .rst_n(rst_n), .push(push_cont), .push_idx(req_chan),
        .pop(pop_cont), .head(cont_head), .empty(cont_empty)
    );

    rcs_idx_queue #(.DEPTH(NCH), .W(CH_W)) u_new_q (
        .clk(clk), .rst_n(rst_n), .push(push_new), .push_idx(req_chan),
        .pop(pop_new), .head(new_head), .empty(new_empty)
    );

    rcs_chunk_calc #(.W(LEN_W)) u_chunk (
        .want(ch_want[act_ch]), .left(ch_left[act_ch]), .chunk(chunk), .whole(whole)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:     if (req_acc) state_d = S_FIFO_BLK;
            S_FIFO_BLK: if (pop_cont || pop_new) state_d = S_BEGIN;
            S_BEGIN:    state_d = (ch_addr[act_ch] == NO_DMA_ADDR) ? S_DONE : S_COPY;
            S_COPY:     if (dma_done) state_d = S_DONE;
            S_DONE:     state_d = (cont_empty && new_empty && !req_acc) ? S_IDLE : S_FIFO_BLK;
            default:    state_d = S_IDLE;
        endcase
    end

    always_comb begin
        pop_cont  = 1'b0;
        pop_new   = 1'b0;
        dma_req   = 1'b0;
        rel_valid = 1'b0;
        sel_ch    = cont_head;
        unique case (state_q)
            S_FIFO_BLK: begin
                if (!cont_empty) begin
                    pop_cont = 1'b1;
                end else if (!new_empty && unclaimed_valid) begin
                    pop_new = 1'b1;
                    sel_ch  = new_head;
                end
            end
            S_COPY:  dma_req   = 1'b1;
            S_DONE:  rel_valid = act_full;
            default: ;
        endcase
    end

    assign claim    = pop_new;
    assign rel_id   = ch_pid[act_ch];
    assign dma_addr = ch_addr[act_ch];
    assign dma_len  = act_len;
    assign dma_off  = ch_off[act_ch];
    assign dma_pid  = ch_pid[act_ch];
    assign dma_virt = ch_virt[act_ch];
    assign rd_done  = done_q[rd_chan];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NCH; i++) begin
                ch_addr[i] <= '0;
                ch_want[i] <= '0;
                ch_off[i]  <= '0;
                ch_left[i] <= '0;
                ch_pid[i]  <= '0;
                ch_virt[i] <= 1'b0;
                ch_has[i]  <= 1'b0;
                done_q[i]  <= '0;
            end
            act_ch     <= '0;
            act_len    <= '0;
            act_full   <= 1'b0;
            intr_dma   <= 1'b0;
            intr_empty <= 1'b0;
            cpl_chan   <= '0;
        end else begin
            intr_dma   <= 1'b0;
            intr_empty <= 1'b0;
            if (req_acc) begin
                ch_addr[req_chan] <= req_desc[ADDR_W-1:0];
                ch_want[req_chan] <= req_desc[LEN_LSB +: LEN_W];
                ch_virt[req_chan] <= req_desc[VIRT_BIT];
                done_q[req_chan]  <= mk_done(1'b1, 1'b0, 1'b0, '0);
            end
            if (pop_cont || pop_new) act_ch <= sel_ch;
            if (pop_new) begin
                ch_has[new_head]  <= 1'b1;
                ch_pid[new_head]  <= unclaimed_id;
                ch_off[new_head]  <= '0;
                ch_left[new_head] <= unclaimed_len;
            end
            if (state_q == S_BEGIN) begin
                act_len  <= chunk;
                act_full <= whole;
            end
            if (state_q == S_DONE) begin
                intr_dma <= 1'b1;
                cpl_chan <= act_ch;
                if (act_full) begin
                    done_q[act_ch] <= mk_done(1'b0, 1'b1, 1'b0, act_len);
                    ch_has[act_ch] <= 1'b0;
                    intr_empty     <= (resident_cnt == CNT_W'(1));
                end else begin
                    done_q[act_ch]  <= mk_done(1'b0, 1'b1, 1'b1, ch_left[act_ch] - act_len);
                    ch_left[act_ch] <= ch_left[act_ch] - act_len;
                    ch_off[act_ch]  <= ch_off[act_ch] + act_len;
                end
            end
        end
    end
endmodule

// File: rtl/rcs_sched_chk.sv
module rcs_sched_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_err,
    input logic        claim,
    input logic        rel_valid,
    input logic        dma_req,
    input logic        dma_done,
    input logic [39:0] dma_addr,
    input logic [19:0] dma_len,
    input logic        intr_dma,
    input logic        intr_empty
);
    // R7
    sentinel_no_dma_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req |-> dma_addr != 40'd1);
    // R3
    err_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_err |-> req_valid);
    // R8
    release_then_cpl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rel_valid |=> intr_dma);
    // R10
    empty_with_cpl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        intr_empty |-> intr_dma);
    // R6
    dma_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req && !dma_done |=> dma_req && $stable(dma_len) && $stable(dma_addr));
    // R5
    claim_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({claim, rel_valid, dma_req}));
endmodule

bind rcs_sched rcs_sched_chk u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_err(req_err),
    .claim(claim), .rel_valid(rel_valid), .dma_req(dma_req), .dma_done(dma_done),
    .dma_addr(dma_addr), .dma_len(dma_len), .intr_dma(intr_dma), .intr_empty(intr_empty)
);

// File: tb/rcs_sched_tb.sv
module rcs_sched_tb;
    localparam int NCH = 4;
    localparam int PID_W = 3;
    localparam int CNT_W = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [1:0] req_chan = '0;
    logic [60:0] req_desc = '0;
    logic req_err, claim, rel_valid, dma_req, dma_virt, intr_dma, intr_empty;
    logic [PID_W-1:0] rel_id, dma_pid, unclaimed_id;
    logic [39:0] dma_addr;
    logic [19:0] dma_len, dma_off, unclaimed_len;
    logic dma_done = 1'b0;
    logic [1:0] rd_chan = '0;
    logic [31:0] rd_done;
    logic [1:0] cpl_chan;
    logic unclaimed_valid;
    logic [CNT_W-1:0] resident_cnt;

    int pkt_len [8];
    int n_pushed = 0, n_claimed = 0, n_released = 0;
    int m_has [NCH], m_pid [NCH], m_off [NCH], m_rem [NCH];
    int m_next = 0;
    int cpl_log [1024];
    bit emp_log [1024];
    int cpl_n = 0;
    int last_rel = -1;
    int dma_cnt = 0;
    logic [39:0] last_addr;
    logic [19:0] last_len, last_off;
    logic last_virt;
    bit dma_hold = 1'b0;
    int n_chk = 0, n_bad = 0;
    bit finished = 1'b0;

    assign unclaimed_valid = (n_claimed < n_pushed);
    assign unclaimed_id    = PID_W'(n_claimed % 8);
    assign unclaimed_len   = 20'(pkt_len[n_claimed % 8]);
    assign resident_cnt    = CNT_W'(n_pushed - n_released);

    rcs_sched #(.NCH(NCH), .PID_W(PID_W), .CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_chan(req_chan),
        .req_desc(req_desc), .req_err(req_err), .unclaimed_valid(unclaimed_valid),
        .unclaimed_id(unclaimed_id), .unclaimed_len(unclaimed_len),
        .resident_cnt(resident_cnt), .claim(claim), .rel_valid(rel_valid),
        .rel_id(rel_id), .dma_req(dma_req), .dma_addr(dma_addr), .dma_len(dma_len),
        .dma_off(dma_off), .dma_pid(dma_pid), .dma_virt(dma_virt), .dma_done(dma_done),
        .rd_chan(rd_chan), .rd_done(rd_done), .intr_dma(intr_dma),
        .intr_empty(intr_empty), .cpl_chan(cpl_chan)
    );

    always #5 clk = ~clk;

    task automatic chk(input string rq, input string what, input logic [63:0] act,
                       input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    task automatic finish_up();
        if (!finished) begin
            finished = 1'b1;
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    endtask

    // buffer model and completion log
    initial begin
        forever begin
            @(posedge clk);
            if (claim) n_claimed <= n_claimed + 1;
            if (rel_valid) begin
                n_released <= n_released + 1;
                last_rel <= int'(rel_id);
            end
            if (intr_dma) begin
                cpl_log[cpl_n % 1024] <= int'(cpl_chan);
                emp_log[cpl_n % 1024] <= intr_empty;
                cpl_n <= cpl_n + 1;
            end
        end
    end

    // DMA engine model
    initial begin
        forever begin
            @(negedge clk);
            if (dma_req && !dma_hold) begin
                dma_cnt++;
                last_addr = dma_addr;
                last_len  = dma_len;
                last_off  = dma_off;
                last_virt = dma_virt;
                repeat ($urandom % 3) @(negedge clk);
                dma_done = 1'b1;
                @(negedge clk);
                dma_done = 1'b0;
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired");
        finish_up();
    end

    task automatic push_pkt(input int len);
        pkt_len[n_pushed % 8] = len;
        n_pushed++;
    endtask

    // reference: apply one copy to the channel model
    task automatic model_step(input int c, input int want, output logic [31:0] exp_w,
                              output int chunk, output int off, output bit full,
                              output int pid);
        if (m_has[c] == 0) begin
            m_has[c] = 1;
            m_pid[c] = m_next % 8;
            m_off[c] = 0;
            m_rem[c] = pkt_len[m_next % 8];
            m_next++;
        end
        pid   = m_pid[c];
        off   = m_off[c];
        chunk = (want < m_rem[c]) ? want : m_rem[c];
        full  = (chunk == m_rem[c]);
        if (full) begin
            exp_w = 32'h4000_0000 | 32'(chunk);
            m_has[c] = 0;
        end else begin
            m_rem[c] = m_rem[c] - chunk;
            m_off[c] = m_off[c] + chunk;
            exp_w = 32'h6000_0000 | 32'(m_rem[c]);
        end
    endtask

    task automatic send_req(input int c, input int len, input logic [39:0] a, input bit v);
        @(negedge clk);
        req_valid = 1'b1;
        req_chan  = 2'(c);
        req_desc  = {v, 20'(len), a};
    endtask

    task automatic do_copy(input int c, input int len, input logic [39:0] a, input bit v,
                           input int late_pkt);
        logic [31:0] exp_w;
        int chunk, off, pid, start_cpl, start_dma;
        bit full, exp_emp;
        start_cpl = cpl_n;
        start_dma = dma_cnt;
        send_req(c, len, a, v);
        @(negedge clk);
        req_valid = 1'b0;
        rd_chan = 2'(c);
        #1;
        chk("R2", "busy bit after request", 64'(rd_done[31]), 64'd1);
        if (late_pkt > 0) begin
            repeat (20) @(negedge clk);
            chk("R5", "no completion without packet", 64'(cpl_n), 64'(start_cpl));
            chk("R5", "no dma without packet", 64'(dma_cnt), 64'(start_dma));
            push_pkt(late_pkt);
        end
        model_step(c, len, exp_w, chunk, off, full, pid);
        exp_emp = full && ((n_pushed - n_released) == 1);
        for (int k = 0; k < 300 && cpl_n == start_cpl; k++) @(negedge clk);
        chk("R10", "completion count", 64'(cpl_n), 64'(start_cpl + 1));
        chk("R10", "completion channel", 64'(cpl_log[start_cpl % 1024]), 64'(c));
        chk("R10", "drained pulse", 64'(emp_log[start_cpl % 1024]), 64'(exp_emp));
        rd_chan = 2'(c);
        #1;
        chk(full ? "R8" : "R9", "status word", 64'(rd_done), 64'(exp_w));
        if (a == 40'd1) begin
            chk("R7", "no dma for sentinel", 64'(dma_cnt), 64'(start_dma));
        end else begin
            chk("R6", "dma count", 64'(dma_cnt), 64'(start_dma + 1));
            chk("R6", "dma length", 64'(last_len), 64'(chunk));
            chk("R9", "dma offset", 64'(last_off), 64'(off));
            chk("R2", "dma address", 64'(last_addr), 64'(a));
            chk("R2", "dma virtual flag", 64'(last_virt), 64'(v));
        end
        if (full) chk("R8", "released id", 64'(last_rel), 64'(pid));
    endtask

    initial begin
        int c, len;
        int exp_order [4];
        int start_cpl, start_dma;
        logic [39:0] a;
        logic [31:0] exp_w;
        int chunk, off, pid;
        bit full;
        for (int i = 0; i < NCH; i++) begin
            m_has[i] = 0; m_pid[i] = 0; m_off[i] = 0; m_rem[i] = 0;
        end
        for (int i = 0; i < 8; i++) pkt_len[i] = 0;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        for (int i = 0; i < NCH; i++) begin
            rd_chan = 2'(i);
            #1;
            chk("R1", "status word after reset", 64'(rd_done), 64'd0);
        end
        chk("R1", "dma_req after reset", 64'(dma_req), 64'd0);
        chk("R1", "intr_dma after reset", 64'(intr_dma), 64'd0);
        chk("R1", "intr_empty after reset", 64'(intr_empty), 64'd0);

        // R5: wait for a packet, then claim it at offset 0
        do_copy(0, 80, 40'h1000, 1'b0, 64);
        // R9: partial copies across one packet
        push_pkt(150);
        do_copy(1, 60, 40'h2000, 1'b1, 0);
        do_copy(1, 60, 40'h3000, 1'b0, 0);
        do_copy(1, 200, 40'h4000, 1'b0, 0);
        // R7: sentinel address
        push_pkt(30);
        do_copy(2, 100, 40'd1, 1'b0, 0);

        // R4, R11, R3: hold DMA so that both queues fill
        push_pkt(500);
        do_copy(0, 100, 40'h5000, 1'b0, 0);
        push_pkt(40);
        push_pkt(300);
        push_pkt(20);
        start_cpl = cpl_n;
        start_dma = dma_cnt;
        dma_hold = 1'b1;
        send_req(2, 50, 40'h6000, 1'b0);
        @(negedge clk);
        req_valid = 1'b0;
        for (int k = 0; k < 50 && !dma_req; k++) @(negedge clk);
        send_req(2, 70, 40'h6100, 1'b0);
        #1;
        chk("R3", "req_err on busy channel", 64'(req_err), 64'd1);
        send_req(1, 100, 40'h7000, 1'b0);
        #1;
        chk("R3", "req_err on idle channel", 64'(req_err), 64'd0);
        send_req(3, 100, 40'h8000, 1'b0);
        send_req(0, 100, 40'h9000, 1'b0);
        @(negedge clk);
        req_valid = 1'b0;
        repeat (5) @(negedge clk);
        dma_hold = 1'b0;
        for (int k = 0; k < 500 && cpl_n < start_cpl + 4; k++) @(negedge clk);
        repeat (20) @(negedge clk);
        chk("R3", "completions with dropped request", 64'(cpl_n), 64'(start_cpl + 4));
        chk("R3", "dma count with dropped request", 64'(dma_cnt), 64'(start_dma + 4));
        exp_order[0] = 2; exp_order[1] = 0; exp_order[2] = 1; exp_order[3] = 3;
        chk("R4", "first served", 64'(cpl_log[start_cpl % 1024]), 64'(exp_order[0]));
        chk("R4", "continuation before new", 64'(cpl_log[(start_cpl + 1) % 1024]), 64'(exp_order[1]));
        chk("R11", "new queue order first", 64'(cpl_log[(start_cpl + 2) % 1024]), 64'(exp_order[2]));
        chk("R11", "new queue order second", 64'(cpl_log[(start_cpl + 3) % 1024]), 64'(exp_order[3]));
        for (int k = 0; k < 4; k++) begin
            c = exp_order[k];
            len = (c == 2) ? 50 : 100;
            model_step(c, len, exp_w, chunk, off, full, pid);
            rd_chan = 2'(c);
            #1;
            chk(full ? "R8" : "R9", "status after queued service", 64'(rd_done), 64'(exp_w));
        end

        // random phase
        for (int it = 0; it < 150; it++) begin
            c = int'($urandom % NCH);
            len = 1 + int'($urandom % 400);
            if ($urandom % 6 == 0) a = 40'd1;
            else a = 40'(($urandom % 100000) + 2) << 4;
            if (m_has[c] == 0 && n_pushed == m_next) push_pkt(1 + int'($urandom % 600));
            if ((n_pushed - n_released) < 6 && ($urandom % 4 == 0))
                push_pkt(1 + int'($urandom % 600));
            do_copy(c, len, a, 1'($urandom % 2), 0);
        end
        finish_up();
    end
endmodule